// File: doc/BRIEF.md
# Half-Bridge Gate Command Conditioner

This block sits on the ground side of a two-channel half-bridge gate driver. It accepts a high-side command, a low-side command, an active-high shutdown request and a pair of digital flags from the low-side supply monitor. It produces the gated high-side and low-side drive commands that feed level translation and output stages. Every input first passes through a multi-flop synchroniser. Both channels then share one pipeline, so they see the same delay.

A shutdown request does more than mask the outputs while it is present. It sets a latch, and the latch keeps both outputs off after the request goes away, until a fresh turn-on command arrives. The supply monitor has two flags: one signals that the supply has fallen below the lower threshold, and one signals that it has risen above the upper threshold. Together they model the detector's hysteresis. While the lockout holds, both outputs stay off. When it releases, any command already high shows up at the output again without a new edge.

A build-time option selects single-input operation. In that mode the high-side command alone drives a pair of complementary outputs, and a programmable deadtime, counted in clock cycles, separates one output turning off from the other turning on.

Top module: `hb_gate_ctl`

## Requirements
- R1: While the synchronised shutdown input is 1, both outputs are 0. An output reaches 0 no later than SYNC_STAGES+1 clock edges after the shutdown input rises.
- R2: In dual-input mode (SINGLE_IN=0), hs_drv_o follows hi_cmd_i and ls_drv_o follows lo_cmd_i independently of each other, and both may be 1 at the same time.
- R3: The lockout is engaged out of reset. A 1 on uv_low_i engages it, and this flag wins over uv_ok_i. While the lockout is engaged, both outputs are 0.
- R4: When a 1 on uv_ok_i releases the lockout, a command that is already 1 (the low-side command in particular) drives its output to 1 without any new edge on that command.
- R5: After shutdown returns to 0, both outputs stay 0 until a command turns on. In dual mode that is a 0-to-1 edge on either command; in single mode it is a new turn-on of either complementary output. A falling command edge does not release the outputs.
- R6: In dual mode, a change on either command input reaches its output SYNC_STAGES+2 clock edges later (4 with defaults). This delay is the same for both channels and for both turn-on and turn-off.
- R7: In single-input mode, hs_drv_o takes the value of hi_cmd_i and ls_drv_o takes its complement. The two outputs are never 1 together.
- R8: In single-input mode, the output being turned off goes to 0 SYNC_STAGES+2 edges after the command changes. The other output goes to 1 exactly DEADTIME edges after that, so both outputs are 0 for at least DEADTIME cycles at every hand-over.
- R9: In single-input mode, lo_cmd_i has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd_i | input | 1 | High-side command (the only command in single-input mode) |
| lo_cmd_i | input | 1 | Low-side command (unused in single-input mode) |
| sd_i | input | 1 | Active-high shutdown request |
| uv_low_i | input | 1 | Supply has fallen below the lower threshold: engage the lockout |
| uv_ok_i | input | 1 | Supply has risen above the upper threshold: release the lockout |
| hs_drv_o | output | 1 | Gated high-side drive command |
| ls_drv_o | output | 1 | Gated low-side drive command |

## Verification
A shutdown latch stuck in the wrong state shows up within one pipeline delay. The outputs either return while the shutdown request is still high, or they stay dark after a new rising command has arrived. A lockout flag that is wrong shows up the same way, both at power-up and when the supply flags toggle. It is caught best by holding the low-side command high across the release. If the deadtime counter loads the wrong value, or a stage is added to one channel, the outputs move to 1 one or more edges earlier or later than the requirements say. That is why the checks sample at the exact edge rather than after settling.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
   typedef struct packed {
      logic hi;
      logic lo;
   } hbg_pair_t;

   localparam int unsigned HBG_NUM_IN = 5;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbg_uvlo.sv
module hbg_uvlo (
   input  logic clk,
   input  logic rst_n,
   input  logic low_i,
   input  logic ok_i,
   output logic lock_o
);
   // Lockout engaged from reset; the below-threshold flag wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lock_o <= 1'b1;
      else if (low_i) lock_o <= 1'b1;
      else if (ok_i)  lock_o <= 1'b0;
   end
endmodule

// File: rtl/hbg_deadtime.sv
module hbg_deadtime
   import hbg_pkg::*;
#(
   parameter int unsigned DEADTIME = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cmd_i,
   output hbg_pair_t drv_o
);
   localparam int unsigned CW = (DEADTIME < 2) ? 1 : $clog2(DEADTIME);
   localparam logic [CW-1:0] LOAD = CW'(DEADTIME - 1);

   if (DEADTIME < 1) begin : g_bad_dt
      $error("hbg_deadtime: DEADTIME must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   hbg_pair_t     drv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q <= '0;
         cnt_q <= '0;
      end else if (cmd_i) begin
         if (drv_q.lo) begin
            drv_q.lo <= 1'b0;
            cnt_q    <= LOAD;
         end else if (!drv_q.hi) begin
            if (cnt_q != '0) cnt_q    <= cnt_q - 1'b1;
            else             drv_q.hi <= 1'b1;
         end
      end else begin
         if (drv_q.hi) begin
            drv_q.hi <= 1'b0;
            cnt_q    <= LOAD;
         end else if (!drv_q.lo) begin
            if (cnt_q != '0) cnt_q    <= cnt_q - 1'b1;
            else             drv_q.lo <= 1'b1;
         end
      end
   end

   assign drv_o = drv_q;
endmodule

// File: rtl/hb_gate_ctl.sv
module hb_gate_ctl
   import hbg_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SINGLE_IN   = 1'b0,
   parameter int unsigned DEADTIME    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hi_cmd_i,
   input  logic lo_cmd_i,
   input  logic sd_i,
   input  logic uv_low_i,
   input  logic uv_ok_i,
   output logic hs_drv_o,
   output logic ls_drv_o
);
   logic [HBG_NUM_IN-1:0] raw_in, syn_in;
   logic      s_hi, s_lo, s_sd, s_uvlow, s_uvok;
   logic      uv_lock;
   hbg_pair_t core, core_prev, rise;
   logic      new_cmd, sd_latched_q, blocked;

   assign raw_in = {hi_cmd_i, lo_cmd_i, sd_i, uv_low_i, uv_ok_i};

   hbg_sync #(.WIDTH(HBG_NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in)
   );

   assign {s_hi, s_lo, s_sd, s_uvlow, s_uvok} = syn_in;

   hbg_uvlo u_uvlo (
      .clk(clk), .rst_n(rst_n), .low_i(s_uvlow), .ok_i(s_uvok), .lock_o(uv_lock)
   );

   // Command stage: one register in either variant keeps the delay equal.
   if (SINGLE_IN) begin : g_single
      hbg_deadtime #(.DEADTIME(DEADTIME)) u_dt (
         .clk(clk), .rst_n(rst_n), .cmd_i(s_hi), .drv_o(core)
      );
   end else begin : g_dual
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) core <= '0;
         else        core <= '{hi: s_hi, lo: s_lo};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) core_prev <= '0;
      else        core_prev <= core;
   end

   assign rise    = core & ~core_prev;
   assign new_cmd = rise.hi | rise.lo;

   // Shutdown latch: set by the request, cleared by a fresh turn-on.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sd_latched_q <= 1'b0;
      else if (s_sd)    sd_latched_q <= 1'b1;
      else if (new_cmd) sd_latched_q <= 1'b0;
   end

   assign blocked = s_sd | uv_lock | (sd_latched_q & ~new_cmd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_drv_o <= 1'b0;
         ls_drv_o <= 1'b0;
      end else begin
         hs_drv_o <= core.hi & ~blocked;
         ls_drv_o <= core.lo & ~blocked;
      end
   end
endmodule

// File: rtl/hb_gate_ctl_chk.sv
module hb_gate_ctl_chk #(
   parameter bit          SINGLE_IN = 1'b0,
   parameter int unsigned DEADTIME  = 4
) (
   input logic clk,
   input logic rst_n,
   input logic sd_sync,
   input logic uv_lock,
   input logic sd_latched,
   input logic new_cmd,
   input logic hs_o,
   input logic ls_o
);
   localparam int unsigned GW = $clog2(DEADTIME + 1) + 1;

   logic [GW-1:0] gap_q;
   logic          had_high_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q      <= '0;
         had_high_q <= 1'b0;
      end else begin
         if (hs_o || ls_o) begin
            gap_q      <= '0;
            had_high_q <= 1'b1;
         end else if (gap_q < GW'(DEADTIME)) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   a_r1_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
      sd_sync |=> (!hs_o && !ls_o));

   a_r3_lockout_off: assert property (@(posedge clk) disable iff (!rst_n)
      uv_lock |=> (!hs_o && !ls_o));

   a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_latched && !new_cmd) |=> (!hs_o && !ls_o));

   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      SINGLE_IN |-> !(hs_o && ls_o));

   a_r8_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
      (SINGLE_IN && had_high_q && $rose(ls_o)) |-> (gap_q >= GW'(DEADTIME)));

   a_r8_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
      (SINGLE_IN && had_high_q && $rose(hs_o)) |-> (gap_q >= GW'(DEADTIME)));
endmodule

bind hb_gate_ctl hb_gate_ctl_chk #(.SINGLE_IN(SINGLE_IN), .DEADTIME(DEADTIME)) u_chk (
   .clk(clk), .rst_n(rst_n), .sd_sync(s_sd), .uv_lock(uv_lock),
   .sd_latched(sd_latched_q), .new_cmd(new_cmd), .hs_o(hs_drv_o), .ls_o(ls_drv_o)
);

// File: tb/hb_gate_ctl_bench.sv
module hb_gate_ctl_bench;
   localparam int DT = 3;
   localparam int NV = 12;
   // {hi, lo, sd, uv_low, uv_ok, exp_hs, exp_ls}
   localparam logic [6:0] VEC [NV] = '{
      7'b00000_00,   // R3 locked from reset
      7'b11000_00,   // R3 commands high, still locked
      7'b01001_01,   // R4 release, lo already high resumes
      7'b10000_10,   // R2 follow
      7'b11000_11,   // R2 both high in dual mode
      7'b11100_00,   // R1 shutdown
      7'b11000_00,   // R5 latched after removal
      7'b01000_00,   // R5 falling edge does not clear
      7'b11000_11,   // R5 rising hi clears
      7'b11010_00,   // R3 lockout engaged
      7'b11001_11,   // R4 both resume on release
      7'b00000_00    // R2 both off
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic hi = 1'b0, lo = 1'b0, sd = 1'b0, uvl = 1'b0, uvk = 1'b0;
   logic hs, ls, hs_s, ls_s;
   int   errors = 0, checks = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   hb_gate_ctl u_hb_gate_ctl (
      .clk(clk), .rst_n(rst_n), .hi_cmd_i(hi), .lo_cmd_i(lo), .sd_i(sd),
      .uv_low_i(uvl), .uv_ok_i(uvk), .hs_drv_o(hs), .ls_drv_o(ls)
   );

   hb_gate_ctl #(.SINGLE_IN(1'b1), .DEADTIME(DT)) u_hb_gate_ctl_single (
      .clk(clk), .rst_n(rst_n), .hi_cmd_i(hi), .lo_cmd_i(lo), .sd_i(sd),
      .uv_low_i(uvl), .uv_ok_i(uvk), .hs_drv_o(hs_s), .ls_drv_o(ls_s)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {hs,ls} actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      step(3);
      check("R3 reset dual", {hs, ls}, 2'b00);
      check("R3 reset single", {hs_s, ls_s}, 2'b00);
      rst_n = 1'b1;
      step(2);

      for (int i = 0; i < NV; i++) begin
         {hi, lo, sd, uvl, uvk} = VEC[i][6:2];
         step(6);
         check($sformatf("R1-5 vector %0d", i), {hs, ls}, VEC[i][1:0]);
      end
      uvk = 1'b0;
      step(10);

      // R6: equal delay, both channels, on and off
      hi = 1'b1; step(3); check("R6 hs on early", {hs, ls}, 2'b00);
      step(1);            check("R6 hs on at edge 4", {hs, ls}, 2'b10);
      lo = 1'b1; step(3); check("R6 ls on early", {hs, ls}, 2'b10);
      step(1);            check("R6 ls on at edge 4", {hs, ls}, 2'b11);
      hi = 1'b0; lo = 1'b0;
      step(3);            check("R6 off early", {hs, ls}, 2'b11);
      step(1);            check("R6 off at edge 4", {hs, ls}, 2'b00);
      step(10);

      // R7/R8: single-input complementary with deadtime
      check("R7 single idle low cmd", {hs_s, ls_s}, 2'b01);
      hi = 1'b1;
      step(3);            check("R8 ls still on", {hs_s, ls_s}, 2'b01);
      step(1);            check("R8 ls off at edge 4", {hs_s, ls_s}, 2'b00);
      step(DT - 1);       check("R8 deadtime both low", {hs_s, ls_s}, 2'b00);
      step(1);            check("R8 hs on after deadtime", {hs_s, ls_s}, 2'b10);
      // R9: lo_cmd ignored in single mode
      lo = 1'b1; step(6); check("R9 lo high ignored", {hs_s, ls_s}, 2'b10);
      lo = 1'b0; step(6); check("R9 lo low ignored", {hs_s, ls_s}, 2'b10);
      hi = 1'b0;
      step(4);            check("R8 hs off at edge 4", {hs_s, ls_s}, 2'b00);
      step(DT - 1);       check("R8 deadtime reverse", {hs_s, ls_s}, 2'b00);
      step(1);            check("R7 ls on complementary", {hs_s, ls_s}, 2'b01);

      // R5 single mode: latch holds until new turn-on
      sd = 1'b1; step(6); check("R1 single shutdown", {hs_s, ls_s}, 2'b00);
      sd = 1'b0; step(6); check("R5 single latched", {hs_s, ls_s}, 2'b00);
      hi = 1'b1; step(6 + DT); check("R5 single new turn-on", {hs_s, ls_s}, 2'b10);

      done = 1'b1;
      finish_run();
   end
endmodule